// File: doc/BRIEF.md
# ADC Serial Configuration Shifter

This block sends a configuration frame to an external serial analog-to-digital converter and collects the converter's reply. Writing a 32-bit synchronous-I/O word starts a transfer. The block then asserts a select strobe and drives a serial clock divided down from the system clock. It shifts the frame out most-significant bit first and captures the returning bits into a 16-bit readback word, which it marks with a one-cycle done pulse.

Two control bits set the transfer shape. The extended-mode bit picks the frame. When the bit is clear, the frame is the low byte of the word and is always 8 bits long. When the bit is set, the frame comes from the upper half-word, and its length (8 to 16 bits) is taken from the seven lowest bits of the word. The edge-select bit picks which serial-clock edge launches data and which edge samples it. The idle level of the serial clock follows from that choice.

Top module: `adc_cfg_shifter`

## Requirements
- R1: After reset, select, busy, done and data out are low, the readback word is zero, both control bits are clear, and the serial clock idles high.
- R2: With extended mode clear, the frame is word bits 7:0, sent MSB first, and is exactly 8 bits long. The upper half-word and the length bits have no effect.
- R3: With extended mode set, the frame is the upper L bits of word bits 31:16, sent MSB first starting at bit 31. L is the value in word bits 6:0. Bit 7 of the word has no effect on L.
- R4: In extended mode, a length value below 8 gives an 8-bit frame, and a length value above 16 gives a 16-bit frame.
- R5: With edge select set (1), data out changes on rising serial-clock edges, data in is sampled on falling edges, and the clock idles low.
- R6: With edge select clear (0), data out changes on falling edges, data in is sampled on rising edges, and the clock idles high.
- R7: Busy rises in the cycle after the word is written and stays high until the transfer ends. Word writes and control writes made while busy are ignored.
- R8: Done is a one-cycle pulse at the end of each transfer. In that cycle the readback word holds the L captured bits, right-justified, first-captured bit most significant, with the upper bits zero. The readback word changes only together with done.
- R9: Select rises one half-period before the first serial-clock edge and falls one half-period after the last edge. Data out is low whenever select is low.
- R10: A serial-clock half-period is CLK_DIV/2 system clocks. Each frame has exactly 2·L edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Write strobe for the synchronous-I/O word; starts a transfer |
| cfg_word_i | input | 32 | Synchronous-I/O word |
| ctl_wr_i | input | 1 | Write strobe for the control bits |
| edge_sel_i | input | 1 | Edge select: 1 launches on rising and samples on falling |
| ext_mode_i | input | 1 | Extended-mode select |
| sdi_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Divided serial clock |
| sdo_o | output | 1 | Serial data to the converter |
| sel_o | output | 1 | Select strobe, active high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rdata_o | output | 16 | Captured readback word |

## Verification
The hardest case to reach is a new word and a control change that both arrive in the middle of a frame. To get there, the bench waits until several serial-clock edges have passed, then writes a different word and the opposite edge mode. It then checks that the frame on the pins, the bit count and the idle level after the transfer all match the first request. The clamp boundaries also need care: a length of zero with bit 7 set, and a length of 127, are only reachable in extended mode. The bench covers both through its vector table, with a converter model that replies on the opposite edge.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/adc_cfg_frame.sv
module adc_cfg_frame #(
  parameter int WORD_W      = 32,
  parameter int FIELD_W     = 16,
  parameter int LEGACY_W    = 8,
  parameter int LEN_FIELD_W = 7,
  parameter int LEN_W       = 5
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic               ext_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [LEN_W-1:0]   len_o
);
  localparam logic [LEN_FIELD_W-1:0] MIN_L = LEN_FIELD_W'(LEGACY_W);
  localparam logic [LEN_FIELD_W-1:0] MAX_L = LEN_FIELD_W'(FIELD_W);

  logic [LEN_FIELD_W-1:0] len_raw;
  assign len_raw = word_i[LEN_FIELD_W-1:0];

  always_comb begin
    if (ext_i) begin
      field_o = word_i[WORD_W-1 -: FIELD_W];
      if (len_raw < MIN_L)      len_o = LEN_W'(LEGACY_W);
      else if (len_raw > MAX_L) len_o = LEN_W'(FIELD_W);
      else                      len_o = len_raw[LEN_W-1:0];
    end else begin
      // legacy byte left-aligned so MSB-first shifting is uniform
      field_o = {word_i[LEGACY_W-1:0], {(FIELD_W-LEGACY_W){1'b0}}};
      len_o   = LEN_W'(LEGACY_W);
    end
  end
endmodule

// File: rtl/adc_cfg_tick.sv
module adc_cfg_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_cfg_shift.sv
module adc_cfg_shift #(
  parameter int FIELD_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               launch_i,
  input  logic               capture_i,
  input  logic               finish_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic [FIELD_W-1:0] rx_o
);
  logic [FIELD_W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_o  <= '0;
      sdo_o <= 1'b0;
    end else if (load_i) begin
      tx_q  <= field_i;
      rx_o  <= '0;
      sdo_o <= 1'b0;
    end else if (launch_i) begin
      sdo_o <= tx_q[FIELD_W-1];
      tx_q  <= {tx_q[FIELD_W-2:0], 1'b0};
    end else if (capture_i) begin
      rx_o  <= {rx_o[FIELD_W-2:0], sdi_i};
    end else if (finish_i) begin
      sdo_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_cfg_shifter.sv
module adc_cfg_shifter #(
  parameter int CLK_DIV     = 4,
  parameter int WORD_W      = 32,
  parameter int FIELD_W     = 16,
  parameter int LEGACY_W    = 8,
  parameter int LEN_FIELD_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [WORD_W-1:0]  cfg_word_i,
  input  logic               ctl_wr_i,
  input  logic               edge_sel_i,
  input  logic               ext_mode_i,
  input  logic               sdi_i,
  output logic               sclk_o,
  output logic               sdo_o,
  output logic               sel_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [FIELD_W-1:0] rdata_o
);
  import adc_cfg_pkg::*;

  localparam int HALF  = CLK_DIV / 2;
  localparam int LEN_W = $clog2(FIELD_W + 1);
  localparam int ECNT_W = LEN_W + 1;

  xfer_state_e        state_q;
  logic               edge_q, ext_q;
  logic [LEN_W-1:0]   len_q;
  logic [ECNT_W-1:0]  ecnt_q;
  logic [ECNT_W-1:0]  last_edge;
  logic [FIELD_W-1:0] field;
  logic [LEN_W-1:0]   len;
  logic [FIELD_W-1:0] rx;
  logic               tick, start, launch, capture, finish, active;

  assign active    = (state_q != ST_IDLE);
  assign start     = cfg_wr_i && !active;
  assign last_edge = {len_q, 1'b0} - ECNT_W'(1);
  assign launch    = tick && ((state_q == ST_LEAD) ||
                              (state_q == ST_SHIFT && !ecnt_q[0]));
  assign capture   = tick && (state_q == ST_SHIFT) && ecnt_q[0];
  assign finish    = tick && (state_q == ST_TRAIL);

  adc_cfg_frame #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W), .LEGACY_W(LEGACY_W),
    .LEN_FIELD_W(LEN_FIELD_W), .LEN_W(LEN_W)
  ) u_frame (
    .word_i (cfg_word_i),
    .ext_i  (ext_q),
    .field_o(field),
    .len_o  (len)
  );

  adc_cfg_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active),
    .tick_o(tick)
  );

  adc_cfg_shift #(.FIELD_W(FIELD_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .field_i  (field),
    .launch_i (launch),
    .capture_i(capture),
    .finish_i (finish),
    .sdi_i    (sdi_i),
    .sdo_o    (sdo_o),
    .rx_o     (rx)
  );

  // control bits frozen while a frame is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (ctl_wr_i && !active) begin
      edge_q <= edge_sel_i;
      ext_q  <= ext_mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_o  <= 1'b1;
      len_q   <= '0;
      ecnt_q  <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sclk_o <= ~edge_q;
          if (start) begin
            state_q <= ST_LEAD;
            len_q   <= len;
            ecnt_q  <= '0;
          end
        end
        ST_LEAD: if (tick) begin
          sclk_o  <= ~sclk_o;
          ecnt_q  <= ECNT_W'(1);
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          sclk_o <= ~sclk_o;
          ecnt_q <= ecnt_q + 1'b1;
          if (ecnt_q == last_edge) state_q <= ST_TRAIL;
        end
        ST_TRAIL: if (tick) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          rdata_o <= rx;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_o  = active;
  assign busy_o = active;
endmodule

// File: rtl/adc_cfg_shifter_chk.sv
module adc_cfg_shifter_chk #(
  parameter int FIELD_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ctl_wr_i,
  input logic               sclk_o,
  input logic               sdo_o,
  input logic               sel_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [FIELD_W-1:0] rdata_o
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));

  p_done_ends_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_busy_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_sdo_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> !sdo_o);

  p_sclk_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_o && !$past(sel_o) && !$past(ctl_wr_i) && !$past(ctl_wr_i, 2))
      |-> $stable(sclk_o));
endmodule

bind adc_cfg_shifter adc_cfg_shifter_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctl_wr_i(ctl_wr_i),
  .sclk_o  (sclk_o),
  .sdo_o   (sdo_o),
  .sel_o   (sel_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .rdata_o (rdata_o)
);

// File: tb/adc_cfg_shifter_bench.sv
`timescale 1ns/1ps
module adc_cfg_shifter_bench;
  localparam int    CLK_DIV = 6;
  localparam int    HALF    = CLK_DIV / 2;
  localparam real   TCLK    = 4.0;
  localparam int    NVEC    = 8;
  // {edge_sel, ext_mode, word[31:0], reply[15:0]}
  localparam logic [49:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 32'hFFFF_00A5, 16'h003C},
    {1'b1, 1'b0, 32'h1234_0096, 16'h00C3},
    {1'b0, 1'b1, 32'hBEEF_0010, 16'hA55A},
    {1'b1, 1'b1, 32'hC0DE_000C, 16'hF123},
    {1'b1, 1'b1, 32'h8001_0003, 16'h00FF},
    {1'b0, 1'b1, 32'h7FFE_007F, 16'h0001},
    {1'b0, 1'b1, 32'h5555_0009, 16'h01AB},
    {1'b1, 1'b1, 32'h0F0F_0080, 16'h005A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        ctl_wr = 1'b0;
  logic        edge_sel = 1'b0;
  logic        ext_mode = 1'b0;
  logic        sdi = 1'b0;
  logic        sclk, sdo, sel, busy, done;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  // converter model state
  logic        cur_edge = 1'b0;
  logic [15:0] slv_tx = '0;
  logic [31:0] sent = '0;
  int          n_edge = 0;
  int          n_cap = 0;
  bit          bad_gap = 1'b0;
  realtime     t_sel_r = 0, t_sel_f = 0, t_first = 0, t_last = 0;

  always #(TCLK/2) clk = ~clk;

  adc_cfg_shifter #(.CLK_DIV(CLK_DIV)) u_adc_cfg_shifter (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_word_i(cfg_word),
    .ctl_wr_i(ctl_wr), .edge_sel_i(edge_sel), .ext_mode_i(ext_mode),
    .sdi_i(sdi), .sclk_o(sclk), .sdo_o(sdo), .sel_o(sel), .busy_o(busy),
    .done_o(done), .rdata_o(rdata)
  );

  always @(posedge sel) t_sel_r = $realtime;
  always @(negedge sel) t_sel_f = $realtime;

  always @(sclk) begin
    if (sel) begin
      if (n_edge == 0) t_first = $realtime;
      else if ($realtime - t_last != HALF * TCLK) bad_gap = 1'b1;
      t_last = $realtime;
      n_edge++;
      if (sclk == cur_edge) begin   // launch edge: reply bit out
        sdi    = slv_tx[15];
        slv_tx = {slv_tx[14:0], 1'b0};
      end else begin                // capture edge: frame bit in
        sent = {sent[30:0], sdo};
        n_cap++;
      end
    end
  end

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * TCLK);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung act=running exp=finished");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic x, input logic [6:0] v);
    if (!x) return 8;
    if (v < 8) return 8;
    if (v > 16) return 16;
    return int'(v);
  endfunction

  task automatic set_ctl(input logic e, input logic x);
    @(negedge clk); ctl_wr = 1'b1; edge_sel = e; ext_mode = x;
    @(negedge clk); ctl_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic arm(input logic e, input logic [15:0] rep, input int len);
    cur_edge = e;
    slv_tx = rep << (16 - len);
    sent = '0; n_edge = 0; n_cap = 0; bad_gap = 1'b0;
  endtask

  task automatic kick(input logic [31:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk({req, " done seen"}, {31'd0, done}, 32'd1);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic run_vec(input logic e, input logic x, input logic [31:0] w,
                         input logic [15:0] rep, input string req);
    int len;
    logic [31:0] exp_tx, exp_rx;
    len    = blen(x, w[6:0]);
    exp_tx = x ? (32'(w[31:16]) >> (16 - len)) : 32'(w[7:0]);
    exp_rx = 32'(rep) & ((32'd1 << len) - 1);
    set_ctl(e, x);
    arm(e, rep, len);
    kick(w);
    chk("R7 busy after write", {31'd0, busy}, 32'd1);
    wait_done(req);
    chk({req, " frame bits"}, sent, exp_tx);
    chk("R10 edge count", n_edge, 2 * len);
    chk("R8 readback", 32'(rdata), exp_rx);
    chk("R10 half period", {31'd0, bad_gap}, 32'd0);
    chk("R9 lead", int'((t_first - t_sel_r) / TCLK), HALF);
    chk("R9 trail", int'((t_sel_f - t_last) / TCLK), HALF);
    chk(e ? "R5 idle low" : "R6 idle high", {31'd0, sclk}, {31'd0, ~e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sel", {31'd0, sel}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 sclk idle", {31'd0, sclk}, 32'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 sdo", {31'd0, sdo}, 32'd0);
    chk("R1 rdata", 32'(rdata), 32'd0);
    chk("R1 sclk idle after release", {31'd0, sclk}, 32'd1);

    // R1 default mode: legacy, falling launch, without any control write
    arm(1'b0, 16'h0055, 8);
    kick(32'hABCD_0F33);
    wait_done("R1 default frame");
    chk("R2 default legacy bits", sent, 32'h33);
    chk("R6 default readback", 32'(rdata), 32'h55);

    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i][49], VECS[i][48], VECS[i][47:16], VECS[i][15:0],
              VECS[i][48] ? (i == 4 || i == 5 || i == 7 ? "R4" : "R3") :
                            (VECS[i][49] ? "R5" : "R2"));
    end

    // R7: new word and control write mid-frame are ignored
    set_ctl(1'b1, 1'b0);
    arm(1'b1, 16'h0081, 8);
    kick(32'h0000_00A5);
    repeat (12) @(negedge clk);
    chk("R7 busy mid frame", {31'd0, busy}, 32'd1);
    @(negedge clk); cfg_wr = 1'b1; cfg_word = 32'hFFFF_0010;
    ctl_wr = 1'b1; edge_sel = 1'b0; ext_mode = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; ctl_wr = 1'b0;
    wait_done("R7");
    chk("R7 frame unchanged", sent, 32'hA5);
    chk("R7 edge count", n_edge, 16);
    chk("R7 readback", 32'(rdata), 32'h81);
    repeat (3) @(negedge clk);
    chk("R7 ctl ignored idle level", {31'd0, sclk}, 32'd0);
    chk("R7 no second frame", {31'd0, busy}, 32'd0);
    // control still legacy/rising: a plain frame confirms it
    arm(1'b1, 16'h0042, 8);
    kick(32'hFFFF_0010);
    wait_done("R7 follow-up");
    chk("R7 legacy kept", sent, 32'h10);
    chk("R5 rising launch readback", 32'(rdata), 32'h42);

    summary();
  end
endmodule